// File: doc/BRIEF.md
# Interrupt Controller Programming Front End

This block is the byte-wide register interface of an eight-line interrupt controller. Software reaches it through a one-bit address, separate write and read strobes and an 8-bit data bus. Writes at address 0 fall into three classes, chosen by bits 4 and 3: an initialization start, an operation command that sets up reads, polling and special mask, or an end-of-interrupt or priority command picked by the top three bits. Writes at address 1 either feed the initialization word sequence or load the interrupt mask.

The initialization sequence depends on its data. The start word records whether a final mode word will follow and whether the controller stands alone. The sequence then takes a vector base word. It takes a cascade word only when the controller is not alone or no mode word is due. It ends with the mode word when one was requested. Reads return the request vector or the in-service vector, as selected, at address 0, and the mask at address 1. When poll is armed, any read instead returns the poll answer and disarms poll.

The outputs are configuration levels and one-cycle command strobes that a separate priority core acts on. The priority arithmetic itself sits outside this block.

Top module: `pic_prog_if`

## Requirements
- R1: After reset the mask, vector base and all mode flags are zero, `init_busy` is low, `eoi_op` is 0, and an address-0 read returns `req_vec`.
- R2: A write at address 0 with bit 4 set pulses `init_start` for one cycle, so the core drops its output and clears its state. It clears the mask, vector base, auto-EOI, fully-nested, rotate, special-mask, poll and read-select state, and raises `init_busy`.
- R3: The first address-1 write after an initialization start loads `vec_base` with the data's low three bits forced to zero.
- R4: If the start word had bit 1 (alone) and bit 0 (mode word needed) both set, the write that follows the base word is taken as the mode word.
- R5: In all other cases the write after the base word is a cascade word. It changes no output. Afterwards the sequence waits for the mode word if bit 0 was set, or otherwise returns to normal with `init_busy` low.
- R6: The mode word sets `fully_nested` from bit 4 and `auto_eoi` from bit 1, and ends the sequence.
- R7: With `init_busy` low, an address-1 write loads `mask_vec` in the next cycle.
- R8: An address-0 write with bit 4 clear and bit 3 set is an operation command. Bit 2 arms poll. With bit 1 set, bit 0 selects the in-service vector (1) or the request vector (0) for address-0 reads. With bit 6 set, bit 5 becomes `special_mask`. A cleared bit 1 or bit 6 leaves its field unchanged.
- R9: An address-0 write with bits 4 and 3 clear is decoded by bits 7:5. Codes 0 and 4 clear and set `rot_on_aeoi`. Code 1 gives `eoi_op`=1 (non-specific EOI), 5 gives 2 (rotating EOI), 3 gives 3 (specific EOI), 6 gives 4 (set priority) and 7 gives 5 (specific rotate), each for one cycle with `eoi_lvl` = bits 2:0. Code 2 does nothing.
- R10: A read while poll is armed returns `{5'b0, poll_id}` if `poll_hit` is set and 8'h07 otherwise. It asserts `poll_ack` during the read and disarms poll, so the next read returns the register again.
- R11: A start word with bit 3 set pulses `level_err` for one cycle. The bit has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 1 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high, zero otherwise |
| req_vec | input | 8 | Request vector from the priority core |
| svc_vec | input | 8 | In-service vector from the priority core |
| poll_hit | input | 1 | Core has a winning request |
| poll_id | input | 3 | Line number of the winning request |
| mask_vec | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| single_mode | output | 1 | Controller runs without a cascade partner |
| fully_nested | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_on_aeoi | output | 1 | Rotate priority on automatic EOI |
| special_mask | output | 1 | Special mask mode |
| init_busy | output | 1 | Initialization sequence in progress |
| init_start | output | 1 | One-cycle pulse: core resets and drops its output |
| level_err | output | 1 | One-cycle pulse: level-sensitive mode was requested |
| poll_ack | output | 1 | Read consumed a poll answer this cycle |
| eoi_op | output | 3 | One-cycle priority command code, 0 when idle |
| eoi_lvl | output | 3 | Line number carried by the command |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle, that each strobe lasts a single cycle, and that `wdata` and `addr` are stable whenever a strobe is high. The bench drives every access through one write task and one read task. Each task raises exactly one strobe for one cycle, changes inputs only on the falling edge, and leaves an idle gap between accesses, so the stimulus stays inside these assumptions. The priority-core inputs are static values the bench sets, so each read has a known expected value.

// File: rtl/pic_prog_pkg.sv
`timescale 1ns/1ps
// Shared types for the interrupt controller programming front end.
// Assumes eight request lines; command codes are fixed by the port contract.
package pic_prog_pkg;

    localparam int N_LINES = 8;
    localparam int ID_W    = $clog2(N_LINES);

    // Position in the initialization word sequence.
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_BASE   = 2'd1,
        ST_CASC   = 2'd2,
        ST_MODE   = 2'd3
    } init_st_e;

    // Priority command codes presented on eoi_op.
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_EOI      = 3'd1,
        OP_ROT_EOI  = 3'd2,
        OP_SPEC_EOI = 3'd3,
        OP_SET_PRI  = 3'd4,
        OP_SPEC_ROT = 3'd5
    } eoi_op_e;

endpackage

// File: rtl/pic_wr_decode.sv
`timescale 1ns/1ps
// Classifies a bus write into one of four kinds. Purely combinational.
// Assumes wr_en is a single-cycle strobe with stable addr and class bits.
module pic_wr_decode (
    input  logic       wr_en,
    input  logic       addr,
    input  logic [1:0] cls_bits,   // write data bits 4:3
    output logic       is_init,
    output logic       is_opcmd,
    output logic       is_prio,
    output logic       is_data
);
    // One-hot write class from address and data bits 4 and 3.
    always_comb begin
        is_init  = wr_en && !addr && cls_bits[1];
        is_opcmd = wr_en && !addr && !cls_bits[1] && cls_bits[0];
        is_prio  = wr_en && !addr && !cls_bits[1] && !cls_bits[0];
        is_data  = wr_en && addr;
    end
endmodule

// File: rtl/pic_init_seq.sv
`timescale 1ns/1ps
// Initialization word sequencer and holder of the mask, vector base and
// mode-word flags. Assumes at most one decoded write class per cycle.
module pic_init_seq #(
    parameter int N_LINES = 8,
    parameter int BASE_LSB = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               is_init,
    input  logic               is_data,
    input  logic [N_LINES-1:0] wdata,
    output logic [N_LINES-1:0] mask_vec,
    output logic [N_LINES-1:0] vec_base,
    output logic               single_mode,
    output logic               fully_nested,
    output logic               auto_eoi,
    output logic               init_busy,
    output logic               init_start,
    output logic               level_err
);
    import pic_prog_pkg::*;

    localparam logic [N_LINES-1:0] BASE_KEEP = {{(N_LINES-BASE_LSB){1'b1}}, {BASE_LSB{1'b0}}};

    init_st_e state_q;
    logic     need_mode_q;

    // Sequence state, captured flags and the registers it owns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_NORMAL;
            need_mode_q  <= 1'b0;
            single_mode  <= 1'b0;
            mask_vec     <= '0;
            vec_base     <= '0;
            fully_nested <= 1'b0;
            auto_eoi     <= 1'b0;
        end else if (is_init) begin
            state_q      <= ST_BASE;
            need_mode_q  <= wdata[0];
            single_mode  <= wdata[1];
            mask_vec     <= '0;
            vec_base     <= '0;
            fully_nested <= 1'b0;
            auto_eoi     <= 1'b0;
        end else if (is_data) begin
            unique case (state_q)
                ST_NORMAL: mask_vec <= wdata;
                ST_BASE: begin
                    vec_base <= wdata & BASE_KEEP;
                    state_q  <= (single_mode && need_mode_q) ? ST_MODE : ST_CASC;
                end
                ST_CASC: state_q <= need_mode_q ? ST_MODE : ST_NORMAL;
                ST_MODE: begin
                    fully_nested <= wdata[4];
                    auto_eoi     <= wdata[1];
                    state_q      <= ST_NORMAL;
                end
                default: state_q <= ST_NORMAL;
            endcase
        end
    end

    // One-cycle strobes raised by a start word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_start <= 1'b0;
            level_err  <= 1'b0;
        end else begin
            init_start <= is_init;
            level_err  <= is_init && wdata[3];
        end
    end

    // Busy whenever the sequence waits for a further word.
    always_comb init_busy = (state_q != ST_NORMAL);
endmodule

// File: rtl/pic_ocw_ctrl.sv
`timescale 1ns/1ps
// Operation and priority command handling: poll, read select, special mask,
// rotate-on-auto-EOI and the one-cycle priority command strobe.
// Assumes a start word clears all of this state.
module pic_ocw_ctrl #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            is_init,
    input  logic            is_opcmd,
    input  logic            is_prio,
    input  logic            rd_en,
    input  logic [2:0]      hi_bits,   // write data bits 7:5
    input  logic [ID_W-1:0] lo_bits,   // write data bits 2:0
    output logic            poll_armed,
    output logic            rd_svc_sel,
    output logic            special_mask,
    output logic            rot_on_aeoi,
    output logic            poll_ack,
    output logic [2:0]      eoi_op,
    output logic [ID_W-1:0] eoi_lvl
);
    import pic_prog_pkg::*;

    // Read consumes the poll answer while poll is armed.
    always_comb poll_ack = rd_en && poll_armed;

    // Operation command fields and poll disarm on read.
    always_ff @(posedge clk) begin
        if (!rst_n || is_init) begin
            poll_armed   <= 1'b0;
            rd_svc_sel   <= 1'b0;
            special_mask <= 1'b0;
        end else if (is_opcmd) begin
            if (lo_bits[2]) poll_armed <= 1'b1;
            if (lo_bits[1]) rd_svc_sel <= lo_bits[0];
            if (hi_bits[1]) special_mask <= hi_bits[0];
        end else if (poll_ack) begin
            poll_armed <= 1'b0;
        end
    end

    // Priority command decode into a one-cycle strobe and rotate flag.
    always_ff @(posedge clk) begin
        if (!rst_n || is_init) begin
            rot_on_aeoi <= 1'b0;
            eoi_op      <= OP_NONE;
            eoi_lvl     <= '0;
        end else begin
            eoi_op <= OP_NONE;
            if (is_prio) begin
                eoi_lvl <= lo_bits;
                unique case (hi_bits)
                    3'd0: rot_on_aeoi <= 1'b0;
                    3'd4: rot_on_aeoi <= 1'b1;
                    3'd1: eoi_op <= OP_EOI;
                    3'd5: eoi_op <= OP_ROT_EOI;
                    3'd3: eoi_op <= OP_SPEC_EOI;
                    3'd6: eoi_op <= OP_SET_PRI;
                    3'd7: eoi_op <= OP_SPEC_ROT;
                    default: eoi_op <= OP_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/pic_rd_mux.sv
`timescale 1ns/1ps
// Read data selection. Combinational; zero when no read is in progress.
// Assumes poll_hit/poll_id are valid in the cycle of the read.
module pic_rd_mux #(
    parameter int N_LINES = 8,
    parameter int ID_W = 3
) (
    input  logic               rd_en,
    input  logic               addr,
    input  logic               poll_armed,
    input  logic               rd_svc_sel,
    input  logic               poll_hit,
    input  logic [ID_W-1:0]    poll_id,
    input  logic [N_LINES-1:0] req_vec,
    input  logic [N_LINES-1:0] svc_vec,
    input  logic [N_LINES-1:0] mask_vec,
    output logic [N_LINES-1:0] rdata
);
    localparam logic [N_LINES-1:0] NO_HIT = N_LINES'(N_LINES - 1);

    // Poll answer overrides the register view.
    always_comb begin
        if (!rd_en)          rdata = '0;
        else if (poll_armed) rdata = poll_hit ? N_LINES'(poll_id) : NO_HIT;
        else if (addr)       rdata = mask_vec;
        else                 rdata = rd_svc_sel ? svc_vec : req_vec;
    end
endmodule

// File: rtl/pic_prog_if.sv
`timescale 1ns/1ps
// Top of the programming front end: write classification, init sequencing,
// command handling and read selection for one eight-line controller.
// Assumes single-cycle, mutually exclusive write and read strobes.
module pic_prog_if (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] req_vec,
    input  logic [7:0] svc_vec,
    input  logic       poll_hit,
    input  logic [2:0] poll_id,
    output logic [7:0] mask_vec,
    output logic [7:0] vec_base,
    output logic       single_mode,
    output logic       fully_nested,
    output logic       auto_eoi,
    output logic       rot_on_aeoi,
    output logic       special_mask,
    output logic       init_busy,
    output logic       init_start,
    output logic       level_err,
    output logic       poll_ack,
    output logic [2:0] eoi_op,
    output logic [2:0] eoi_lvl
);
    import pic_prog_pkg::*;

    logic is_init, is_opcmd, is_prio, is_data;
    logic poll_armed, rd_svc_sel;

    pic_wr_decode u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .cls_bits (wdata[4:3]),
        .is_init  (is_init),
        .is_opcmd (is_opcmd),
        .is_prio  (is_prio),
        .is_data  (is_data)
    );

    pic_init_seq #(.N_LINES(N_LINES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .is_init      (is_init),
        .is_data      (is_data),
        .wdata        (wdata),
        .mask_vec     (mask_vec),
        .vec_base     (vec_base),
        .single_mode  (single_mode),
        .fully_nested (fully_nested),
        .auto_eoi     (auto_eoi),
        .init_busy    (init_busy),
        .init_start   (init_start),
        .level_err    (level_err)
    );

    pic_ocw_ctrl #(.ID_W(ID_W)) u_ocw (
        .clk          (clk),
        .rst_n        (rst_n),
        .is_init      (is_init),
        .is_opcmd     (is_opcmd),
        .is_prio      (is_prio),
        .rd_en        (rd_en),
        .hi_bits      (wdata[7:5]),
        .lo_bits      (wdata[2:0]),
        .poll_armed   (poll_armed),
        .rd_svc_sel   (rd_svc_sel),
        .special_mask (special_mask),
        .rot_on_aeoi  (rot_on_aeoi),
        .poll_ack     (poll_ack),
        .eoi_op       (eoi_op),
        .eoi_lvl      (eoi_lvl)
    );

    pic_rd_mux #(.N_LINES(N_LINES), .ID_W(ID_W)) u_rd (
        .rd_en      (rd_en),
        .addr       (addr),
        .poll_armed (poll_armed),
        .rd_svc_sel (rd_svc_sel),
        .poll_hit   (poll_hit),
        .poll_id    (poll_id),
        .req_vec    (req_vec),
        .svc_vec    (svc_vec),
        .mask_vec   (mask_vec),
        .rdata      (rdata)
    );
endmodule

// File: rtl/pic_prog_if_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to the programming front end.
// Assumes wr_en and rd_en never overlap and last one cycle each.
module pic_prog_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] mask_vec,
    input logic       init_busy,
    input logic       init_start,
    input logic       level_err,
    input logic       poll_ack,
    input logic [2:0] eoi_op
);
    // A start word leaves the sequence busy with the mask cleared.
    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (init_busy && mask_vec == 8'h00));

    // The start strobe only follows a start word.
    p_start_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |-> $past(wr_en && !addr && wdata[4]));

    // The sequence only ends on an address-1 write.
    p_seq_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_busy) |-> $past(wr_en && addr));

    // A normal-mode data write lands in the mask.
    p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && !init_busy) |=> (mask_vec == $past(wdata)));

    // Priority command strobes only follow a priority-class write.
    p_cmd_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_op != 3'd0) |-> $past(wr_en && !addr && !wdata[4] && !wdata[3]));

    // Priority command strobes last a single cycle without a new write.
    p_cmd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((eoi_op != 3'd0) && !wr_en) |=> (eoi_op == 3'd0));

    // Poll consumption only happens during a read.
    p_poll_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        poll_ack |-> rd_en);

    // Poll answer is consumed once: back-to-back acks are impossible.
    p_poll_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_ack && !wr_en) |=> !poll_ack);

    // Level-sensitive flag only follows a start word with bit 3 set.
    p_level_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        level_err |-> $past(wr_en && !addr && wdata[4] && wdata[3]));
endmodule

bind pic_prog_if pic_prog_if_chk u_chk (.*);

// File: tb/pic_prog_if_tb.sv
`timescale 1ns/1ps
// Directed bench for the programming front end; one task per scenario.
module pic_prog_if_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] req_vec = 8'hA5, svc_vec = 8'h3C;
    logic       poll_hit = 1'b0;
    logic [2:0] poll_id = 3'd0;
    logic [7:0] mask_vec, vec_base;
    logic       single_mode, fully_nested, auto_eoi, rot_on_aeoi, special_mask;
    logic       init_busy, init_start, level_err, poll_ack;
    logic [2:0] eoi_op, eoi_lvl;

    int n_chk = 0, n_bad = 0;
    logic       c_start, c_lerr;
    logic [2:0] c_op, c_lvl;
    logic [7:0] r_data;
    logic       r_ack;

    always #2.5 clk = ~clk;

    pic_prog_if u_dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write; pulse outputs are captured in the cycle after the edge.
    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        c_start = init_start; c_lerr = level_err; c_op = eoi_op; c_lvl = eoi_lvl;
        @(negedge clk);
    endtask

    task automatic rd(logic a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        r_data = rdata; r_ack = poll_ack;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 mask", mask_vec, 0);
        check("R1 base", vec_base, 0);
        check("R1 flags", {single_mode, fully_nested, auto_eoi, rot_on_aeoi, special_mask, init_busy}, 0);
        check("R1 op", eoi_op, 0);
        rd(1'b0);
        check("R1 read irr", r_data, 8'hA5);
    endtask

    task automatic t_init_full();
        wr(1'b0, 8'h11);
        check("R2 start pulse", c_start, 1);
        check("R2 busy", init_busy, 1);
        check("R11 no level flag", c_lerr, 0);
        check("R2 pulse drops", init_start, 0);
        wr(1'b1, 8'h47);
        check("R3 base", vec_base, 8'h40);
        check("R3 busy", init_busy, 1);
        wr(1'b1, 8'h04);
        check("R5 cascade no effect", {vec_base, mask_vec}, {8'h40, 8'h00});
        check("R5 wait mode", init_busy, 1);
        wr(1'b1, 8'h12);
        check("R6 flags", {fully_nested, auto_eoi}, 2'b11);
        check("R6 done", init_busy, 0);
        check("R6 mask intact", mask_vec, 0);
    endtask

    task automatic t_init_single();
        wr(1'b0, 8'h13);
        check("R2 single", single_mode, 1);
        check("R2 flags cleared", {fully_nested, auto_eoi}, 2'b00);
        wr(1'b1, 8'h2F);
        check("R3 base", vec_base, 8'h28);
        wr(1'b1, 8'h02);
        check("R4 skip cascade", {init_busy, auto_eoi, fully_nested}, 3'b010);
        wr(1'b1, 8'h5A);
        check("R7 mask load", mask_vec, 8'h5A);
        rd(1'b1);
        check("R7 mask read", r_data, 8'h5A);
    endtask

    task automatic t_init_short();
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h08);
        wr(1'b1, 8'hFF);
        check("R5 no mode word", {init_busy, auto_eoi, fully_nested}, 3'b000);
        check("R5 cascade not mask", mask_vec, 8'h00);
        check("R3 base", vec_base, 8'h08);
        wr(1'b0, 8'h18);
        check("R11 level flag", c_lerr, 1);
        check("R11 init still runs", init_busy, 1);
        check("R11 pulse drops", level_err, 0);
        wr(1'b1, 8'h10);
        wr(1'b1, 8'h00);
        check("R11 sequence normal", init_busy, 0);
    endtask

    task automatic t_init_clears();
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h68);
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h0C);
        check("R8 setup", {special_mask, rot_on_aeoi, mask_vec}, {2'b11, 8'hFF});
        wr(1'b0, 8'h10);
        check("R2 clears", {special_mask, rot_on_aeoi, mask_vec}, {2'b00, 8'h00});
        rd(1'b0);
        check("R2 poll and select cleared", {r_ack, r_data}, {1'b0, 8'hA5});
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_opcmd();
        wr(1'b0, 8'h0B);
        rd(1'b0);
        check("R8 select isr", r_data, 8'h3C);
        wr(1'b0, 8'h09);
        rd(1'b0);
        check("R8 bit1 clear keeps select", r_data, 8'h3C);
        wr(1'b0, 8'h0A);
        rd(1'b0);
        check("R8 select irr", r_data, 8'hA5);
        wr(1'b0, 8'h68);
        check("R8 smm set", special_mask, 1);
        wr(1'b0, 8'h28);
        check("R8 bit6 clear keeps smm", special_mask, 1);
        wr(1'b0, 8'h48);
        check("R8 smm clear", special_mask, 0);
    endtask

    task automatic t_poll();
        wr(1'b1, 8'hC3);
        poll_hit = 1'b1; poll_id = 3'd5;
        wr(1'b0, 8'h0C);
        rd(1'b1);
        check("R10 poll hit", {r_ack, r_data}, {1'b1, 8'h05});
        rd(1'b1);
        check("R10 poll disarmed", {r_ack, r_data}, {1'b0, 8'hC3});
        poll_hit = 1'b0;
        wr(1'b0, 8'h0C);
        rd(1'b0);
        check("R10 poll miss", {r_ack, r_data}, {1'b1, 8'h07});
        rd(1'b0);
        check("R10 register after poll", r_data, 8'hA5);
    endtask

    task automatic t_prio();
        wr(1'b0, 8'h20); check("R9 nonspecific", c_op, 3'd1);
        check("R9 pulse ends", eoi_op, 3'd0);
        wr(1'b0, 8'hA0); check("R9 rotating", c_op, 3'd2);
        wr(1'b0, 8'h63); check("R9 specific", {c_op, c_lvl}, {3'd3, 3'd3});
        wr(1'b0, 8'hC5); check("R9 set priority", {c_op, c_lvl}, {3'd4, 3'd5});
        wr(1'b0, 8'hE6); check("R9 specific rotate", {c_op, c_lvl}, {3'd5, 3'd6});
        wr(1'b0, 8'h47); check("R9 code 2 nop", {c_op, rot_on_aeoi}, {3'd0, 1'b0});
        wr(1'b0, 8'h80); check("R9 rotate set", {c_op, rot_on_aeoi}, {3'd0, 1'b1});
        wr(1'b0, 8'h00); check("R9 rotate clear", rot_on_aeoi, 0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_full();
        t_init_single();
        t_init_short();
        t_init_clears();
        t_opcmd();
        t_poll();
        t_prio();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule